// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one output compare channel of a timer subsystem. It watches a 16-bit count from one of two free-running timers and compares it with a primary compare register and a secondary compare register. It then drives a single output pin according to a 3-bit mode. The modes are: disabled; set, clear or toggle on a match; one high pulse framed by two matches; a repeating pulse train; and pulse-width modulation with or without a fault input.

Software reaches the three registers through a plain write port and a combinational read port. Two timer counts, each with a period-match strobe, come in from outside. So do the sleep and idle indications and an active-low fault input. The pin level and the pin drive enable are separate outputs, so a fault disconnect shows as the enable falling while the level is unchanged.

The sequencer has seven states. Each transition is listed below.

- `ST_OFF`: disabled. The pin is low. It does not leave this state until a control write.
- `ST_ARMED`: a single-match mode is waiting for the count to equal the primary register.
  - In set mode a match raises the pin and moves to `ST_LATCHED`.
  - In clear mode a match lowers the pin and moves to `ST_LATCHED`.
  - In toggle mode a match inverts the pin and the state stays `ST_ARMED`.
- `ST_LATCHED`: a single set or clear has happened. The pin holds.
- `ST_WAIT_RISE`: a dual-match mode is waiting for the count to equal the primary register. A match raises the pin and moves to `ST_WAIT_FALL`.
- `ST_WAIT_FALL`: the count is compared with the secondary register. A match lowers the pin.
  - In single-pulse mode it then moves to `ST_SPENT`.
  - In pulse-train mode it then moves back to `ST_WAIT_RISE`.
- `ST_SPENT`: the single pulse is finished. The pin is low.
- `ST_PWM`: both PWM modes. A period match copies the secondary register into the primary register and sets the pin high unless the new duty value is zero. A count equal to the primary register lowers the pin.

Any accepted control write moves the sequencer to the entry state of the newly written mode in the next cycle. The entry states are `ST_OFF`, `ST_ARMED`, `ST_WAIT_RISE` or `ST_PWM`.

Top module: `outcmp_channel`

## Requirements
- R1: After reset the primary, secondary and control registers read 0x0000, the pin level is 0 and the drive enable is 1.
- R2: In mode 001 the pin goes high on the first clock edge at which the selected count equals the primary register. In mode 010 it goes low on that edge. Later matches change nothing until the next control write.
- R3: In mode 011 the pin inverts on every clock edge at which the selected count equals the primary register.
- R4: In mode 100 the pin rises when the count equals the primary register, then falls when the count equals the secondary register, then stays low. A secondary match seen before the rise is ignored.
- R5: In mode 101 the rise and fall of R4 repeat for as long as the mode stays selected.
- R6: In modes 110 and 111 a period match copies the secondary register into the primary register. On that same edge the pin goes high if the copied value is nonzero and low if it is zero. The pin goes low when the count equals the primary register. With a duty value of zero the pin stays low for the whole period.
- R7: Control bit 3 selects the count and period strobe: 0 takes timer A and 1 takes timer B.
- R8: Control bit 13 sets the idle-stop option. With bit 13 = 1 and idle asserted, the sequencer is frozen and register writes are ignored. With bit 13 = 0, operation continues during idle.
- R9: While sleep is asserted, the pin level and all state hold, and register writes are ignored.
- R10: In mode 111 a low fault input drops the drive enable in the same cycle, including during sleep or idle. In all other modes the fault input leaves the enable at 1.
- R11: Control bit 4 reads 1 once a low fault input has been sampled in mode 111. Software writes can neither set nor clear bit 4; only reset clears it.
- R12: A control write with mode 000 drives the pin low on the next edge and discards any dual-match progress. A write of any other mode keeps the current pin level and restarts that mode.
- R13: The read select picks the register: 0 is primary, 1 is secondary, 2 is control, and 3 reads 0. In the control word, bits 2:0 hold the mode, bit 3 the timer select, bit 4 the fault flag and bit 13 the idle-stop bit. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 primary, 1 secondary, 2 control |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read select, same coding plus 3 = zero |
| rd_data | output | 16 | Read data, combinational |
| tmr_a_cnt | input | 16 | Timer A count |
| tmr_a_wrap | input | 1 | Timer A period-match strobe |
| tmr_b_cnt | input | 16 | Timer B count |
| tmr_b_wrap | input | 1 | Timer B period-match strobe |
| idle_i | input | 1 | Device idle indication |
| sleep_i | input | 1 | Device sleep indication (clock stopped) |
| fault_n | input | 1 | Active-low fault input |
| pin_level | output | 1 | Output pin level |
| pin_drive_en | output | 1 | Output pin drive enable (0 = disconnected) |

## Verification
The checker assumes that sleep really stands for a stopped clock, so no register write or mode change arrives while sleep is high. It also assumes that a fault can only disconnect the pin when the fault input itself is low. The stimulus respects both assumptions: every write that the bench issues during sleep is one the block must ignore, and the bench changes counts and strobes only at falling edges. The timer counts are driven as arbitrary values, not as a real counter. This lets a single equal count held over two cycles exercise the toggle mode on every matching edge, and it lets a period match fall on any count.

// File: rtl/outcmp_pkg.sv
package outcmp_pkg;

    typedef enum logic [2:0] {
        MD_OFF     = 3'd0,
        MD_SET     = 3'd1,
        MD_CLR     = 3'd2,
        MD_TGL     = 3'd3,
        MD_PULSE   = 3'd4,
        MD_TRAIN   = 3'd5,
        MD_PWM     = 3'd6,
        MD_PWM_FLT = 3'd7
    } oc_mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARMED,
        ST_LATCHED,
        ST_WAIT_RISE,
        ST_WAIT_FALL,
        ST_SPENT,
        ST_PWM
    } oc_state_e;

    typedef struct packed {
        logic     idle_stop;
        logic     tsel;
        oc_mode_e mode;
    } oc_ctrl_t;

    localparam int CTL_MODE_LSB = 0;
    localparam int CTL_TSEL_BIT = 3;
    localparam int CTL_FLAG_BIT = 4;
    localparam int CTL_IDLE_BIT = 13;

    localparam logic [1:0] SEL_MAIN = 2'd0;
    localparam logic [1:0] SEL_SEC  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    function automatic oc_state_e entry_state(oc_mode_e m);
        case (m)
            MD_OFF:                  return ST_OFF;
            MD_SET, MD_CLR, MD_TGL:  return ST_ARMED;
            MD_PULSE, MD_TRAIN:      return ST_WAIT_RISE;
            default:                 return ST_PWM;
        endcase
    endfunction

endpackage

// File: rtl/outcmp_regs.sv
module outcmp_regs
    import outcmp_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             blocked,
    input  logic             sleep_i,
    input  logic             fault_n,
    input  logic             load_main,
    output logic [REG_W-1:0] main_q,
    output logic [REG_W-1:0] sec_q,
    output oc_ctrl_t         ctrl_q,
    output logic             fault_flag,
    output logic             ctrl_wr,
    output oc_mode_e         wr_mode
);

    logic             wr_ok;
    logic [REG_W-1:0] ctrl_word;

    assign wr_ok   = wr_en && !blocked;
    assign ctrl_wr = wr_ok && (wr_sel == SEL_CTRL);
    assign wr_mode = oc_mode_e'(wr_data[CTL_MODE_LSB +: 3]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
        end else if (load_main) begin
            main_q <= sec_q;
        end else if (wr_ok && wr_sel == SEL_MAIN) begin
            main_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (wr_ok && wr_sel == SEL_SEC) begin
            sec_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{idle_stop: 1'b0, tsel: 1'b0, mode: MD_OFF};
        end else if (ctrl_wr) begin
            ctrl_q.idle_stop <= wr_data[CTL_IDLE_BIT];
            ctrl_q.tsel      <= wr_data[CTL_TSEL_BIT];
            ctrl_q.mode      <= wr_mode;
        end
    end

    // sticky: only the reset input clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_flag <= 1'b0;
        end else if (ctrl_q.mode == MD_PWM_FLT && !fault_n && !sleep_i) begin
            fault_flag <= 1'b1;
        end
    end

    always_comb begin
        ctrl_word                          = '0;
        ctrl_word[CTL_MODE_LSB +: 3]       = ctrl_q.mode;
        ctrl_word[CTL_TSEL_BIT]            = ctrl_q.tsel;
        ctrl_word[CTL_FLAG_BIT]            = fault_flag;
        ctrl_word[CTL_IDLE_BIT]            = ctrl_q.idle_stop;
    end

    always_comb begin
        case (rd_sel)
            SEL_MAIN: rd_data = main_q;
            SEL_SEC:  rd_data = sec_q;
            SEL_CTRL: rd_data = ctrl_word;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/outcmp_tmr_sel.sv
module outcmp_tmr_sel #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_a,
    input  logic             wrap_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic             wrap_b,
    input  logic             sel_b,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    assign cnt  = sel_b ? cnt_b  : cnt_a;
    assign wrap = sel_b ? wrap_b : wrap_a;

endmodule

// File: rtl/outcmp_fsm.sv
module outcmp_fsm
    import outcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             ctrl_wr,
    input  oc_mode_e         wr_mode,
    input  oc_mode_e         mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    input  logic [CNT_W-1:0] main_q,
    input  logic [CNT_W-1:0] sec_q,
    output logic             pin_q,
    output logic             load_main,
    output oc_state_e        state_q
);

    oc_state_e state_n;
    logic      pin_n;
    logic      hit_main;
    logic      hit_sec;

    assign hit_main  = (cnt == main_q);
    assign hit_sec   = (cnt == sec_q);
    assign load_main = !halt && !ctrl_wr && (state_q == ST_PWM) && wrap;

    always_comb begin
        state_n = state_q;
        pin_n   = pin_q;
        if (halt) begin
            state_n = state_q;
        end else if (ctrl_wr) begin
            state_n = entry_state(wr_mode);
            if (wr_mode == MD_OFF) pin_n = 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    pin_n = 1'b0;
                end
                ST_ARMED: begin
                    if (hit_main) begin
                        case (mode)
                            MD_SET: begin
                                pin_n   = 1'b1;
                                state_n = ST_LATCHED;
                            end
                            MD_CLR: begin
                                pin_n   = 1'b0;
                                state_n = ST_LATCHED;
                            end
                            default: pin_n = !pin_q;
                        endcase
                    end
                end
                ST_LATCHED: begin
                    state_n = ST_LATCHED;
                end
                ST_WAIT_RISE: begin
                    if (hit_main) begin
                        pin_n   = 1'b1;
                        state_n = ST_WAIT_FALL;
                    end
                end
                ST_WAIT_FALL: begin
                    if (hit_sec) begin
                        pin_n   = 1'b0;
                        state_n = (mode == MD_TRAIN) ? ST_WAIT_RISE : ST_SPENT;
                    end
                end
                ST_SPENT: begin
                    pin_n = 1'b0;
                end
                ST_PWM: begin
                    if (wrap) begin
                        pin_n = (sec_q != '0);
                    end else if (hit_main) begin
                        pin_n = 1'b0;
                    end
                end
                default: begin
                    state_n = ST_OFF;
                    pin_n   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_n;
    end

endmodule

// File: rtl/outcmp_channel.sv
module outcmp_channel
    import outcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic [CNT_W-1:0] tmr_a_cnt,
    input  logic             tmr_a_wrap,
    input  logic [CNT_W-1:0] tmr_b_cnt,
    input  logic             tmr_b_wrap,
    input  logic             idle_i,
    input  logic             sleep_i,
    input  logic             fault_n,
    output logic             pin_level,
    output logic             pin_drive_en
);

    logic [CNT_W-1:0] main_q;
    logic [CNT_W-1:0] sec_q;
    oc_ctrl_t         ctrl_q;
    logic             fault_flag;
    logic             ctrl_wr;
    oc_mode_e         wr_mode;
    oc_mode_e         cur_mode;
    logic             halt;
    logic             load_main;
    logic [CNT_W-1:0] sel_cnt;
    logic             sel_wrap;
    oc_state_e        fsm_state;

    assign cur_mode     = ctrl_q.mode;
    assign halt         = sleep_i || (idle_i && ctrl_q.idle_stop);
    assign pin_drive_en = !((cur_mode == MD_PWM_FLT) && !fault_n);

    outcmp_regs #(.REG_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .blocked    (halt),
        .sleep_i    (sleep_i),
        .fault_n    (fault_n),
        .load_main  (load_main),
        .main_q     (main_q),
        .sec_q      (sec_q),
        .ctrl_q     (ctrl_q),
        .fault_flag (fault_flag),
        .ctrl_wr    (ctrl_wr),
        .wr_mode    (wr_mode)
    );

    outcmp_tmr_sel #(.CNT_W(CNT_W)) tsel_i (
        .cnt_a  (tmr_a_cnt),
        .wrap_a (tmr_a_wrap),
        .cnt_b  (tmr_b_cnt),
        .wrap_b (tmr_b_wrap),
        .sel_b  (ctrl_q.tsel),
        .cnt    (sel_cnt),
        .wrap   (sel_wrap)
    );

    outcmp_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .ctrl_wr   (ctrl_wr),
        .wr_mode   (wr_mode),
        .mode      (cur_mode),
        .cnt       (sel_cnt),
        .wrap      (sel_wrap),
        .main_q    (main_q),
        .sec_q     (sec_q),
        .pin_q     (pin_level),
        .load_main (load_main),
        .state_q   (fsm_state)
    );

endmodule

// File: rtl/outcmp_channel_chk.sv
module outcmp_channel_chk
    import outcmp_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sleep_i,
    input logic      fault_n,
    input logic      pin_level,
    input logic      pin_drive_en,
    input logic      fault_flag,
    input oc_state_e state,
    input oc_mode_e  mode
);

    a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> $stable(pin_level));

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |=> fault_flag);

    a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && mode == MD_PWM_FLT && !sleep_i) |=> fault_flag);

    a_r10_disconnect_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_drive_en |-> !fault_n);

    a_r12_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !pin_level);

    a_r4_spent_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPENT) |-> !pin_level);

    a_r2_latched_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCHED && mode == MD_SET) |-> pin_level);

endmodule

bind outcmp_channel outcmp_channel_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_i      (sleep_i),
    .fault_n      (fault_n),
    .pin_level    (pin_level),
    .pin_drive_en (pin_drive_en),
    .fault_flag   (fault_flag),
    .state        (fsm_state),
    .mode         (cur_mode)
);

// File: tb/outcmp_channel_tb.sv
`timescale 1ns/1ps
module outcmp_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic [15:0] tmr_a_cnt = 16'h0;
    logic        tmr_a_wrap = 1'b0;
    logic [15:0] tmr_b_cnt = 16'h0;
    logic        tmr_b_wrap = 1'b0;
    logic        idle_i = 1'b0;
    logic        sleep_i = 1'b0;
    logic        fault_n = 1'b1;
    logic        pin_level;
    logic        pin_drive_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    outcmp_channel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .tmr_a_cnt(tmr_a_cnt), .tmr_a_wrap(tmr_a_wrap),
        .tmr_b_cnt(tmr_b_cnt), .tmr_b_wrap(tmr_b_wrap), .idle_i(idle_i), .sleep_i(sleep_i),
        .fault_n(fault_n), .pin_level(pin_level), .pin_drive_en(pin_drive_en)
    );

    // op: 0 none, 1 primary, 2 secondary, 3 control
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] dat;
        logic [15:0] cnt;
        logic        wrap;
        logic        pin;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 16'd5, 16'd0, 1'b0, 1'b0, 4'd2},
        '{2'd2, 16'd8, 16'd1, 1'b0, 1'b0, 4'd2},
        '{2'd3, 16'd1, 16'd2, 1'b0, 1'b0, 4'd2},
        '{2'd0, 16'd0, 16'd4, 1'b0, 1'b0, 4'd2},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b1, 4'd2},
        '{2'd0, 16'd0, 16'd6, 1'b0, 1'b1, 4'd2},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b1, 4'd2},
        '{2'd3, 16'd2, 16'd0, 1'b0, 1'b1, 4'd12},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b0, 4'd2},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b0, 4'd2},
        '{2'd3, 16'd3, 16'd0, 1'b0, 1'b0, 4'd3},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b1, 4'd3},
        '{2'd0, 16'd0, 16'd6, 1'b0, 1'b1, 4'd3},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b0, 4'd3},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b1, 4'd3},
        '{2'd3, 16'd0, 16'd0, 1'b0, 1'b0, 4'd12},
        '{2'd3, 16'd4, 16'd0, 1'b0, 1'b0, 4'd4},
        '{2'd0, 16'd0, 16'd8, 1'b0, 1'b0, 4'd4},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b1, 4'd4},
        '{2'd0, 16'd0, 16'd7, 1'b0, 1'b1, 4'd4},
        '{2'd0, 16'd0, 16'd8, 1'b0, 1'b0, 4'd4},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b0, 4'd4},
        '{2'd3, 16'd5, 16'd0, 1'b0, 1'b0, 4'd5},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b1, 4'd5},
        '{2'd0, 16'd0, 16'd8, 1'b0, 1'b0, 4'd5},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b1, 4'd5},
        '{2'd0, 16'd0, 16'd8, 1'b0, 1'b0, 4'd5},
        '{2'd3, 16'd6, 16'd0, 1'b0, 1'b0, 4'd6},
        '{2'd0, 16'd0, 16'd3, 1'b1, 1'b1, 4'd6},
        '{2'd0, 16'd0, 16'd0, 1'b0, 1'b1, 4'd6},
        '{2'd0, 16'd0, 16'd5, 1'b0, 1'b1, 4'd6},
        '{2'd0, 16'd0, 16'd8, 1'b0, 1'b0, 4'd6},
        '{2'd2, 16'd0, 16'd9, 1'b0, 1'b0, 4'd6},
        '{2'd0, 16'd0, 16'd3, 1'b1, 1'b0, 4'd6},
        '{2'd0, 16'd0, 16'd0, 1'b0, 1'b0, 4'd6},
        '{2'd0, 16'd0, 16'd1, 1'b0, 1'b0, 4'd6},
        '{2'd3, 16'd0, 16'd0, 1'b0, 1'b0, 4'd12}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] sel, input logic [15:0] exp);
        rd_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 pin", {15'd0, pin_level}, 16'd0);
        check("R1 en", {15'd0, pin_drive_en}, 16'd1);
        rd_check("R1 primary", 2'd0, 16'h0000);
        rd_check("R1 secondary", 2'd1, 16'h0000);
        rd_check("R1 control", 2'd2, 16'h0000);

        // vector table: modes R2 R3 R4 R5 R6 R12 on timer A
        for (int i = 0; i < NV; i++) begin
            wr_en      = (VECS[i].op != 2'd0);
            wr_sel     = (VECS[i].op == 2'd0) ? 2'd0 : VECS[i].op - 2'd1;
            wr_data    = VECS[i].dat;
            tmr_a_cnt  = VECS[i].cnt;
            tmr_a_wrap = VECS[i].wrap;
            step();
            wr_en = 1'b0; tmr_a_wrap = 1'b0;
            check($sformatf("R%0d vec%0d", VECS[i].req, i), {15'd0, pin_level}, {15'd0, VECS[i].pin});
        end
        // R6: period match copied the zero duty into primary
        rd_check("R6 duty copy", 2'd0, 16'h0000);

        // R7 timer select
        tmr_a_cnt = 0; tmr_b_cnt = 0;
        wr(2'd0, 16'd10);
        wr(2'd2, 16'h0009);
        tmr_a_cnt = 10; tmr_b_cnt = 3;
        step();
        check("R7 timer A ignored", {15'd0, pin_level}, 16'd0);
        tmr_b_cnt = 10;
        step();
        check("R7 timer B match", {15'd0, pin_level}, 16'd1);
        tmr_a_cnt = 0; tmr_b_cnt = 0;
        wr(2'd2, 16'h0000);
        check("R12 off low", {15'd0, pin_level}, 16'd0);

        // R8 idle stop
        wr(2'd2, 16'h2003);
        idle_i = 1'b1; tmr_a_cnt = 10;
        step();
        check("R8 idle frozen", {15'd0, pin_level}, 16'd0);
        wr(2'd0, 16'd7);
        rd_check("R8 idle write ignored", 2'd0, 16'd10);
        idle_i = 1'b0;
        step();
        check("R8 resumes", {15'd0, pin_level}, 16'd1);
        tmr_a_cnt = 0;
        wr(2'd2, 16'h0003);
        check("R12 mode keeps level", {15'd0, pin_level}, 16'd1);
        idle_i = 1'b1; tmr_a_cnt = 10;
        step();
        check("R8 runs in idle", {15'd0, pin_level}, 16'd0);
        idle_i = 1'b0; tmr_a_cnt = 0;
        step();

        // R9 sleep hold
        sleep_i = 1'b1; tmr_a_cnt = 10;
        step(); step();
        check("R9 sleep hold low", {15'd0, pin_level}, 16'd0);
        wr(2'd2, 16'h0000);
        rd_check("R9 sleep write ignored", 2'd2, 16'h0003);
        sleep_i = 1'b0;
        step();
        check("R9 wake toggles", {15'd0, pin_level}, 16'd1);
        sleep_i = 1'b1;
        step();
        check("R9 sleep hold high", {15'd0, pin_level}, 16'd1);
        sleep_i = 1'b0; tmr_a_cnt = 0;
        wr(2'd2, 16'h0000);

        // R10 R11 fault handling
        fault_n = 1'b0;
        #1;
        check("R10 mode0 enabled", {15'd0, pin_drive_en}, 16'd1);
        step();
        rd_check("R11 no flag mode0", 2'd2, 16'h0000);
        wr(2'd2, 16'h0006);
        check("R10 mode6 enabled", {15'd0, pin_drive_en}, 16'd1);
        rd_check("R11 no flag mode6", 2'd2, 16'h0006);
        wr(2'd2, 16'h0007);
        #1;
        check("R10 disconnect", {15'd0, pin_drive_en}, 16'd0);
        step();
        rd_check("R11 flag set", 2'd2, 16'h0017);
        fault_n = 1'b1;
        #1;
        check("R10 reconnect", {15'd0, pin_drive_en}, 16'd1);
        wr(2'd2, 16'h0007);
        rd_check("R11 write keeps flag", 2'd2, 16'h0017);
        wr(2'd2, 16'h0000);
        rd_check("R11 flag survives mode0", 2'd2, 16'h0010);
        wr(2'd2, 16'h0007);
        sleep_i = 1'b1; fault_n = 1'b0;
        #1;
        check("R10 disconnect in sleep", {15'd0, pin_drive_en}, 16'd0);
        step();
        sleep_i = 1'b0; fault_n = 1'b1;
        step();

        // reset clears flag
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        rd_check("R11 reset clears", 2'd2, 16'h0000);
        check("R1 pin after reset", {15'd0, pin_level}, 16'd0);

        // R13 read decode and control layout
        wr(2'd0, 16'h1234);
        rd_check("R13 primary", 2'd0, 16'h1234);
        rd_check("R13 unused select", 2'd3, 16'h0000);
        wr(2'd2, 16'h200B);
        rd_check("R13 control layout", 2'd2, 16'h200B);
        wr(2'd2, 16'hFFF0);
        rd_check("R13 R11 flag not writable", 2'd2, 16'h2000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule